// File: doc/BRIEF.md
# Multi-Width CRC-32C Accumulator

This block keeps a running CRC-32C (Castagnoli polynomial, reflected bit order) over a stream of data chunks. On each beat the caller picks the chunk width: 8, 16, 32 or 64 bits. Each chunk is folded into the running value in one clock cycle. The updated 32-bit value sits in an internal accumulator register. It is presented zero-extended on a 64-bit result port, one cycle after the strobe.

A beat either continues from the accumulator or starts from a seed supplied on the same beat. This lets software-style loops run over a buffer with any mix of widths. The block applies no pre- or post-inversion. The caller seeds with all ones for the usual convention and inverts the final value itself.

Top module: `crc32c_accum`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid` is 0 and `out_result` is all zeros.
- R2: The update uses the reflected polynomial 0x82F63B78, consuming data LSB first with no built-in XOR at start or end. A zero seed with zero data yields zero. The nine bytes 0x31..0x39, seeded with 0xFFFFFFFF and inverted by the caller, give 0xE3069283.
- R3: `in_width` selects how much of `in_data` is consumed: 0 = bits 7:0, 1 = bits 15:0, 2 = bits 31:0, 3 = bits 63:0. Bits above the selected width have no effect on the result. Within a chunk, bytes are consumed from the least significant byte upward.
- R4: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. The new value appears on `out_result` in that same cycle.
- R5: A valid beat with `in_load` low starts from the current accumulator value, so consecutive beats chain into one CRC.
- R6: A valid beat with `in_load` high starts from `in_seed` and discards the accumulator.
- R7: `out_result[63:32]` is always zero, and `out_result[31:0]` holds the accumulator.
- R8: A cycle with `in_valid` low leaves the accumulator, and so `out_result`, unchanged, whatever the other inputs are.
- R9: Feeding the same byte buffer as single bytes, as 32-bit words or as 64-bit words gives the same final value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Chunk strobe |
| in_load | input | 1 | Start this beat from `in_seed` instead of the accumulator |
| in_seed | input | 32 | Starting CRC value used when `in_load` is high |
| in_data | input | 64 | Data chunk, LSB-aligned |
| in_width | input | 2 | Chunk width code (0:8, 1:16, 2:32, 3:64 bits) |
| out_valid | output | 1 | Result updated in this cycle |
| out_result | output | 64 | Accumulated CRC, zero-extended |

## Verification
The accumulator state is visible directly on `out_result`. A wrong fold, a wrong width select or a stray bit from above the selected width therefore shows as a mismatch one cycle after the offending beat. Because later beats chain from it, the mismatch then persists until the next load. A wrong hold on idle cycles, or a missed seed load, shows on the very next result. The bench compares every beat of a long mixed-width sweep against an arithmetic model. It also checks the standard check string through three different chunkings.

// File: rtl/crc32c_pkg.sv
package crc32c_pkg;
  localparam int          CRC_W     = 32;
  localparam int          DATA_W    = 64;
  localparam logic [31:0] POLY_REFL = 32'h82F63B78;

  typedef enum logic [1:0] {
    CW_8  = 2'd0,
    CW_16 = 2'd1,
    CW_32 = 2'd2,
    CW_64 = 2'd3
  } chunk_w_e;
endpackage

// File: rtl/crc32c_lane.sv
// Unrolled reflected CRC fold for a fixed chunk width.
module crc32c_lane #(
  parameter int               BITS  = 8,
  parameter int               CRC_W = 32,
  parameter logic [CRC_W-1:0] POLY  = 32'h82F63B78
) (
  input  logic [CRC_W-1:0] crc_in,
  input  logic [BITS-1:0]  data,
  output logic [CRC_W-1:0] crc_out
);
  logic [CRC_W-1:0] c;
  logic             fb;

  always_comb begin
    c  = crc_in;
    fb = 1'b0;
    for (int i = 0; i < BITS; i++) begin
      fb = c[0] ^ data[i];
      c  = {1'b0, c[CRC_W-1:1]} ^ (fb ? POLY : '0);
    end
    crc_out = c;
  end
endmodule

// File: rtl/crc32c_select.sv
// Picks the lane result for the requested chunk width.
module crc32c_select #(
  parameter int N     = 4,
  parameter int W     = 32,
  localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][W-1:0] cand,
  input  logic [SEL_W-1:0]    sel,
  output logic [W-1:0]        chosen
);
  always_comb begin
    chosen = cand[0];
    for (int k = 0; k < N; k++)
      if (sel == k[SEL_W-1:0]) chosen = cand[k];
  end
endmodule

// File: rtl/crc32c_accum.sv
module crc32c_accum #(
  parameter int                DATA_W = crc32c_pkg::DATA_W,
  parameter int                CRC_W  = crc32c_pkg::CRC_W,
  parameter logic [CRC_W-1:0]  POLY   = crc32c_pkg::POLY_REFL,
  localparam int               NUM_W  = $clog2(DATA_W / 8) + 1,
  localparam int               WSEL_W = $clog2(NUM_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_load,
  input  logic [CRC_W-1:0]  in_seed,
  input  logic [DATA_W-1:0] in_data,
  input  logic [WSEL_W-1:0] in_width,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result
);
  logic [CRC_W-1:0]            acc_q;
  logic                        vld_q;
  logic [CRC_W-1:0]            start_crc;
  logic [NUM_W-1:0][CRC_W-1:0] lane_crc;
  logic [CRC_W-1:0]            next_crc;

  assign start_crc = in_load ? in_seed : acc_q;

  for (genvar g = 0; g < NUM_W; g++) begin : g_lane
    localparam int LB = 8 << g;
    crc32c_lane #(.BITS(LB), .CRC_W(CRC_W), .POLY(POLY)) u_lane (
      .crc_in (start_crc),
      .data   (in_data[LB-1:0]),
      .crc_out(lane_crc[g])
    );
  end

  crc32c_select #(.N(NUM_W), .W(CRC_W)) u_sel (
    .cand  (lane_crc),
    .sel   (in_width),
    .chosen(next_crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) acc_q <= next_crc;
    end
  end

  assign out_valid  = vld_q;
  assign out_result = {{(DATA_W-CRC_W){1'b0}}, acc_q};
endmodule

// File: rtl/crc32c_accum_chk.sv
module crc32c_accum_chk #(
  parameter int DATA_W = 64,
  parameter int CRC_W  = 32,
  parameter int WSEL_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_load,
  input logic [CRC_W-1:0]  in_seed,
  input logic [DATA_W-1:0] in_data,
  input logic [WSEL_W-1:0] in_width,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!out_valid && out_result == '0)); // R1
  AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_load && in_seed == '0 && in_data == '0) |=> (out_result == '0)); // R2
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R4
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R4
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst) out_result[DATA_W-1:CRC_W] == '0); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(out_result)); // R8
endmodule

bind crc32c_accum crc32c_accum_chk #(.DATA_W(DATA_W), .CRC_W(CRC_W), .WSEL_W(WSEL_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_load(in_load), .in_seed(in_seed),
  .in_data(in_data), .in_width(in_width), .out_valid(out_valid), .out_result(out_result)
);

// File: tb/crc32c_accum_bench.sv
module crc32c_accum_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_load;
  logic [31:0] in_seed;
  logic [63:0] in_data;
  logic [1:0]  in_width;
  logic        out_valid;
  logic [63:0] out_result;

  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;
  logic [31:0] model  = '0;
  logic [63:0] rng    = 64'h9E3779B97F4A7C15;

  crc32c_accum u_crc32c_accum (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_load(in_load), .in_seed(in_seed),
    .in_data(in_data), .in_width(in_width), .out_valid(out_valid), .out_result(out_result)
  );

  always #(PERIOD/2) clk = ~clk;

  // Byte-oriented reference: each byte folded LSB first with the reflected polynomial.
  function automatic logic [31:0] ref_crc(input logic [31:0] c0, input logic [63:0] d, input logic [1:0] w);
    logic [31:0] c = c0;
    int nbytes = 1 << w;
    for (int b = 0; b < nbytes; b++) begin
      c = c ^ {24'h0, d[b*8 +: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'h82F63B78) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [63:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat(input logic v, input logic ld, input logic [31:0] sd,
                      input logic [63:0] d, input logic [1:0] w, input string req);
    @(negedge clk);
    in_valid = v; in_load = ld; in_seed = sd; in_data = d; in_width = w;
    @(posedge clk);
    #1;
    if (v) model = ref_crc(ld ? sd : model, d, w);
    chk({req, " valid"}, {63'h0, out_valid}, {63'h0, v});
    chk({req, " result"}, out_result, {32'h0, model});
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r_byte, r_word, r_dword;
    rst = 1'b1; in_valid = 1'b1; in_load = 1'b1; in_seed = '1; in_data = '1; in_width = 2'd3;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {63'h0, out_valid}, 64'h0);
    chk("R1 reset result", out_result, 64'h0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R1 after reset", out_result, 64'h0);

    // R2 zero in, zero out
    beat(1, 1, 32'h0, 64'h0, 2'd3, "R2 zero");

    // R2/R9 check string byte-wise
    beat(1, 1, 32'hFFFFFFFF, 64'h31, 2'd0, "R6 seed load");
    for (int i = 1; i < 9; i++) beat(1, 0, 32'h0, 64'h30 + 64'(i + 1), 2'd0, "R5 chain bytes");
    r_byte = model;
    chk("R2 check string", {32'h0, ~r_byte}, 64'hE3069283);
    // word-wise with garbage above the width (R3)
    beat(1, 1, 32'hFFFFFFFF, 64'hDEADBEEF34333231, 2'd2, "R3 word");
    beat(1, 0, 32'h0, 64'h0123456738373635, 2'd2, "R3 word");
    beat(1, 0, 32'h0, 64'hFFFFFFFFFFFFFF39, 2'd0, "R3 byte tail");
    r_word = model;
    chk("R9 word vs byte", {32'h0, r_word}, {32'h0, r_byte});
    beat(1, 1, 32'hFFFFFFFF, 64'h3837363534333231, 2'd3, "R3 dword");
    beat(1, 0, 32'h0, 64'hAAAAAAAAAAAA5539, 2'd0, "R3 byte tail");
    r_dword = model;
    chk("R9 dword vs byte", {32'h0, r_dword}, {32'h0, r_byte});

    // R8 idle with noisy inputs
    for (int i = 0; i < 8; i++) beat(0, 1, 32'h12345678, next_rand(), 2'(i), "R8 idle hold");

    // Sweep over widths, data, chaining and loads (R3 R4 R5 R6 R7)
    for (int w = 0; w < 4; w++) begin
      for (int i = 0; i < 250; i++) begin
        logic [63:0] d = next_rand();
        logic        ld = (i % 17) == 0;
        logic        v  = (i % 11) != 5;
        beat(v, ld, d[63:32] ^ 32'h5A5A5A5A, d, 2'(w), "R3 R5 R6 R7 sweep");
      end
    end
    // Mixed-width chaining
    for (int i = 0; i < 300; i++) begin
      logic [63:0] d = next_rand();
      beat(1, (i % 29) == 0, d[31:0], d, d[1:0], "R4 R5 mixed");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule